// File: doc/BRIEF.md
# Next Fetch Address Unit with Tagged Target Buffer and Decode Override

This unit chooses the address the instruction fetch stage uses on the next cycle. A small, fully associative target buffer is searched with the current fetch address. Each entry holds the complete address of a branch as its tag and the target that branch last jumped to. On a match, fetch follows the stored target before the instruction is decoded. Otherwise fetch moves on sequentially by one instruction (4 bytes).

The buffer only learns from branches and jumps that the execute stage reports as taken. A branch that resolves not-taken while it holds an entry loses that entry. One cycle after a fetch, the decode stage reports whether the instruction is a branch, its computed target and the direction predicted by a separate direction table. If the buffer missed that instruction and the table says taken, the unit steers fetch to the decoded target and kills the one younger instruction already fetched.

A misprediction reported by execute overrides every other source. Fetch restarts at the correct address, and every instruction younger than the branch is flushed. Table updates happen only on resolution. An update made in one cycle is visible to lookups from the next cycle on.

Top module: `nextpc_unit`

## Requirements
- R1: While reset is asserted, and after it is released, all buffer entries are invalid. Before any resolution, every fetch address therefore yields next_pc = fetch_pc + 4, and kill_fetch and flush are low.
- R2: When fetch_pc equals the tag of a valid entry, next_pc is that entry's stored target. redirect, kill_fetch and flush stay low.
- R3: When fetch_pc matches no valid entry and no other source is active, next_pc = fetch_pc + 4.
- R4: A resolution with ex_taken = 0 for an address not in the buffer allocates nothing. That address still yields fetch_pc + 4 afterwards.
- R5: A taken resolution for an address already in the buffer rewrites that entry's target in place and does not consume a new entry.
- R6: A resolution with ex_taken = 0 for an address held in the buffer invalidates its entry. From the next cycle, that address yields fetch_pc + 4.
- R7: New entries are placed by a round-robin pointer over the 16 entries. The pointer advances once per allocation, regardless of which entries are valid. The 17th allocation after reset evicts the entry written by the 1st.
- R8: In a cycle with dec_valid, dec_branch and dec_pred_taken all 1, where the buffer missed on the fetch address of the previous cycle and no execute mispredict is present, next_pc = dec_target. kill_fetch and redirect are 1 in that cycle.
- R9: If the buffer hit on the previous cycle's fetch address, a decoded predicted-taken branch causes no redirect and no kill_fetch.
- R10: When ex_valid and ex_mispredict are both 1, next_pc is ex_target if ex_taken is 1, and ex_pc + 4 otherwise. flush and redirect are 1 and kill_fetch is 0. This holds even if a decode override or a buffer hit is present in the same cycle.
- R11: The buffer is written at the clock edge that ends the resolution cycle. A lookup in that same cycle still sees the old contents; a lookup in the next cycle sees the new contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fetch_pc | input | PC_W | Address being fetched this cycle |
| dec_valid | input | 1 | Decode stage holds a live instruction (fetched the previous cycle) |
| dec_branch | input | 1 | The decoded instruction is a branch or jump |
| dec_pred_taken | input | 1 | Direction table predicts taken for the decoded branch |
| dec_target | input | PC_W | Target computed in decode |
| ex_valid | input | 1 | A branch resolves in execute this cycle |
| ex_pc | input | PC_W | Address of the resolving branch |
| ex_taken | input | 1 | Resolved direction |
| ex_target | input | PC_W | Resolved target address |
| ex_mispredict | input | 1 | The resolving branch was mispredicted |
| next_pc | output | PC_W | Address to fetch next cycle |
| redirect | output | 1 | Fetch is being steered by decode or execute |
| kill_fetch | output | 1 | Discard the one instruction fetched behind the decoded branch |
| flush | output | 1 | Discard all instructions younger than the resolving branch |

## Verification
On every cycle, the assertions check three things: execute's priority over all other sources and the target it forces, the agreement of a decode override with its inputs, and the exclusion of kill_fetch and flush. Across two cycles, they check that a taken resolution becomes visible to the next lookup, that a not-taken resolution removes the address, and that a hit on the previous fetch suppresses the decode override. Round-robin eviction order, the absence of allocation for not-taken branches, in-place target rewrites and the clean state after a mid-run reset rely on histories many cycles long. Only the bench's scenarios show those.

// File: rtl/nextpc_pkg.sv
// Shared types for the next fetch address unit.
package nextpc_pkg;
    // Source selected for the next fetch address, lowest to highest priority.
    typedef enum logic [1:0] {
        SRC_SEQ = 2'd0,
        SRC_BUF = 2'd1,
        SRC_DEC = 2'd2,
        SRC_EXE = 2'd3
    } npc_src_e;
endpackage

// File: rtl/nextpc_rr_alloc.sv
// Round-robin victim pointer for buffer allocation.
// Assumes: advance is pulsed once per new allocation; invalid entries are
// not searched for, the pointer simply steps through every slot in turn.
module nextpc_rr_alloc #(
    parameter int ENTRIES = 16,
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             advance,
    output logic [IDX_W-1:0] victim
);
    localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

    logic [IDX_W-1:0] ptr_q;

    // Step the pointer, wrapping after the last slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (advance) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + IDX_W'(1);
        end
    end

    assign victim = ptr_q;
endmodule

// File: rtl/nextpc_btb_store.sv
// Fully associative tag/target store with two search ports (fetch and
// execute), one write port and one invalidate port.
// Assumes: at most one valid entry carries a given tag (the top only
// allocates on a miss), so the match vectors are one-hot or empty.
module nextpc_btb_store #(
    parameter int PC_W    = 32,
    parameter int ENTRIES = 16,
    localparam int IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PC_W-1:0]  f_pc,
    output logic             f_hit,
    output logic [PC_W-1:0]  f_target,
    input  logic [PC_W-1:0]  x_pc,
    output logic             x_hit,
    output logic [IDX_W-1:0] x_idx,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PC_W-1:0]  wr_tag,
    input  logic [PC_W-1:0]  wr_target,
    input  logic             inv_en,
    input  logic [IDX_W-1:0] inv_idx
);
    logic [ENTRIES-1:0] valid_q;
    logic [PC_W-1:0]    tag_q    [ENTRIES];
    logic [PC_W-1:0]    target_q [ENTRIES];
    logic [ENTRIES-1:0] f_match;
    logic [ENTRIES-1:0] x_match;

    for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
        // Hold one entry: write sets it valid, invalidate clears it.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q[e]  <= 1'b0;
                tag_q[e]    <= '0;
                target_q[e] <= '0;
            end else if (wr_en && wr_idx == IDX_W'(e)) begin
                valid_q[e]  <= 1'b1;
                tag_q[e]    <= wr_tag;
                target_q[e] <= wr_target;
            end else if (inv_en && inv_idx == IDX_W'(e)) begin
                valid_q[e]  <= 1'b0;
            end
        end

        assign f_match[e] = valid_q[e] && (tag_q[e] == f_pc);
        assign x_match[e] = valid_q[e] && (tag_q[e] == x_pc);
    end

    // Reduce the fetch match vector to hit and target.
    always_comb begin
        f_target = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (f_match[e]) f_target = f_target | target_q[e];
        end
    end
    assign f_hit = |f_match;

    // Encode the execute match vector into an index.
    always_comb begin
        x_idx = '0;
        for (int e = 0; e < ENTRIES; e++) begin
            if (x_match[e]) x_idx = x_idx | IDX_W'(e);
        end
    end
    assign x_hit = |x_match;
endmodule

// File: rtl/nextpc_select.sv
// Priority selector for the next fetch address.
// Order: execute mispredict, decode override, buffer hit, sequential.
module nextpc_select
    import nextpc_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int INSN_BYTES = 4
) (
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            buf_hit,
    input  logic [PC_W-1:0] buf_target,
    input  logic            dec_take,
    input  logic [PC_W-1:0] dec_target,
    input  logic            exe_fix,
    input  logic            exe_taken,
    input  logic [PC_W-1:0] exe_pc,
    input  logic [PC_W-1:0] exe_target,
    output logic [PC_W-1:0] next_pc,
    output npc_src_e        src
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    // Pick the highest-priority active source.
    always_comb begin
        if (exe_fix) begin
            src     = SRC_EXE;
            next_pc = exe_taken ? exe_target : exe_pc + STEP;
        end else if (dec_take) begin
            src     = SRC_DEC;
            next_pc = dec_target;
        end else if (buf_hit) begin
            src     = SRC_BUF;
            next_pc = buf_target;
        end else begin
            src     = SRC_SEQ;
            next_pc = fetch_pc + STEP;
        end
    end
endmodule

// File: rtl/nextpc_unit.sv
// Next fetch address unit: target buffer lookup in fetch, decode-stage
// override on a buffer miss, execute-stage mispredict recovery.
// Assumes: the instruction in decode this cycle was fetched at the address
// presented on fetch_pc in the previous cycle; one resolution per cycle.
module nextpc_unit
    import nextpc_pkg::*;
#(
    parameter int PC_W       = 32,
    parameter int ENTRIES    = 16,
    parameter int INSN_BYTES = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] fetch_pc,
    input  logic            dec_valid,
    input  logic            dec_branch,
    input  logic            dec_pred_taken,
    input  logic [PC_W-1:0] dec_target,
    input  logic            ex_valid,
    input  logic [PC_W-1:0] ex_pc,
    input  logic            ex_taken,
    input  logic [PC_W-1:0] ex_target,
    input  logic            ex_mispredict,
    output logic [PC_W-1:0] next_pc,
    output logic            redirect,
    output logic            kill_fetch,
    output logic            flush
);
    localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

    logic             buf_hit;
    logic [PC_W-1:0]  buf_target;
    logic             x_hit;
    logic [IDX_W-1:0] x_idx;
    logic [IDX_W-1:0] victim;
    logic             upd_taken;
    logic             alloc;
    logic             inv_en;
    logic [IDX_W-1:0] wr_idx;
    logic             prev_hit_q;
    logic             dec_take;
    logic             exe_fix;
    npc_src_e         src;

    // Resolution bookkeeping: update in place, allocate, or invalidate.
    assign upd_taken = ex_valid && ex_taken;
    assign alloc     = upd_taken && !x_hit;
    assign inv_en    = ex_valid && !ex_taken && x_hit;
    assign wr_idx    = x_hit ? x_idx : victim;

    nextpc_btb_store #(
        .PC_W    (PC_W),
        .ENTRIES (ENTRIES)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .f_pc      (fetch_pc),
        .f_hit     (buf_hit),
        .f_target  (buf_target),
        .x_pc      (ex_pc),
        .x_hit     (x_hit),
        .x_idx     (x_idx),
        .wr_en     (upd_taken),
        .wr_idx    (wr_idx),
        .wr_tag    (ex_pc),
        .wr_target (ex_target),
        .inv_en    (inv_en),
        .inv_idx   (x_idx)
    );

    nextpc_rr_alloc #(
        .ENTRIES (ENTRIES)
    ) u_alloc (
        .clk     (clk),
        .rst_n   (rst_n),
        .advance (alloc),
        .victim  (victim)
    );

    // Remember whether the instruction now entering decode hit the buffer.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_hit_q <= 1'b0;
        else        prev_hit_q <= buf_hit;
    end

    assign dec_take = dec_valid && dec_branch && dec_pred_taken && !prev_hit_q;
    assign exe_fix  = ex_valid && ex_mispredict;

    nextpc_select #(
        .PC_W       (PC_W),
        .INSN_BYTES (INSN_BYTES)
    ) u_select (
        .fetch_pc   (fetch_pc),
        .buf_hit    (buf_hit),
        .buf_target (buf_target),
        .dec_take   (dec_take),
        .dec_target (dec_target),
        .exe_fix    (exe_fix),
        .exe_taken  (ex_taken),
        .exe_pc     (ex_pc),
        .exe_target (ex_target),
        .next_pc    (next_pc),
        .src        (src)
    );

    assign flush      = (src == SRC_EXE);
    assign kill_fetch = (src == SRC_DEC);
    assign redirect   = flush || kill_fetch;
endmodule

// File: rtl/nextpc_unit_chk.sv
// Protocol checker for nextpc_unit, attached by bind below.
// Observes ports only; relates outputs to inputs now and one cycle back.
module nextpc_unit_chk #(
    parameter int PC_W       = 32,
    parameter int INSN_BYTES = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic [PC_W-1:0] fetch_pc,
    input logic            dec_valid,
    input logic            dec_branch,
    input logic            dec_pred_taken,
    input logic [PC_W-1:0] dec_target,
    input logic            ex_valid,
    input logic [PC_W-1:0] ex_pc,
    input logic            ex_taken,
    input logic [PC_W-1:0] ex_target,
    input logic            ex_mispredict,
    input logic [PC_W-1:0] next_pc,
    input logic            redirect,
    input logic            kill_fetch,
    input logic            flush
);
    localparam logic [PC_W-1:0] STEP = PC_W'(INSN_BYTES);

    // R10: execute recovery wins and forces the corrected address.
    a_r10_exec_first: assert property (@(posedge clk) disable iff (!rst_n)
        (ex_valid && ex_mispredict) |->
            (flush && redirect && !kill_fetch &&
             next_pc == (ex_taken ? ex_target : ex_pc + STEP)));

    // R10: the two kill scopes never occur together.
    a_r10_one_scope: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({kill_fetch, flush}));

    // R8: a decode override only follows a predicted-taken decoded branch.
    a_r8_dec_kill: assert property (@(posedge clk) disable iff (!rst_n)
        kill_fetch |->
            (dec_valid && dec_branch && dec_pred_taken &&
             next_pc == dec_target && redirect));

    // R9: a non-sequential, non-redirected fetch (a hit) suppresses override.
    a_r9_hit_no_override: assert property (@(posedge clk) disable iff (!rst_n)
        (!redirect && next_pc != fetch_pc + STEP) |=> !kill_fetch);

    // R11: a taken resolution is visible to the lookup in the next cycle.
    a_r11_update_visible: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ex_valid && ex_taken) &&
         fetch_pc == $past(ex_pc) && !redirect) |->
            next_pc == $past(ex_target));

    // R6: a not-taken resolution removes the address from the buffer.
    a_r6_invalidate: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(ex_valid && !ex_taken) &&
         fetch_pc == $past(ex_pc) && !redirect) |->
            next_pc == fetch_pc + STEP);
endmodule

bind nextpc_unit nextpc_unit_chk #(
    .PC_W       (PC_W),
    .INSN_BYTES (INSN_BYTES)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .fetch_pc       (fetch_pc),
    .dec_valid      (dec_valid),
    .dec_branch     (dec_branch),
    .dec_pred_taken (dec_pred_taken),
    .dec_target     (dec_target),
    .ex_valid       (ex_valid),
    .ex_pc          (ex_pc),
    .ex_taken       (ex_taken),
    .ex_target      (ex_target),
    .ex_mispredict  (ex_mispredict),
    .next_pc        (next_pc),
    .redirect       (redirect),
    .kill_fetch     (kill_fetch),
    .flush          (flush)
);

// File: tb/nextpc_unit_tb.sv
// Self-checking bench for nextpc_unit: vector table, then directed tests.
module nextpc_unit_tb;
    localparam int PC_W = 32;
    localparam int NVEC = 12;

    typedef struct packed {
        logic [31:0] fpc;
        logic        exv;
        logic [31:0] expc;
        logic        ext;
        logic [31:0] extgt;
        logic        exm;
        logic        dv;
        logic        db;
        logic        dt;
        logic [31:0] dtgt;
        logic [31:0] npc;
        logic        kill;
        logic        fl;
        logic [7:0]  req;
    } vec_t;

    // Sequential scenario; each row is one cycle, state carries over.
    localparam vec_t VEC [NVEC] = '{
        // R3: empty buffer, sequential fetch
        '{32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h104, 1'b0, 1'b0, 8'd3},
        // R11: resolve 0x100 taken -> 0x400; same-cycle lookup still misses
        '{32'h100, 1'b1, 32'h100, 1'b1, 32'h400, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h104, 1'b0, 1'b0, 8'd11},
        // R2: hit returns stored target
        '{32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h400, 1'b0, 1'b0, 8'd2},
        // R9: decoded taken branch that hit: no override
        '{32'h104, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b1, 1'b1, 1'b1, 32'h400, 32'h108, 1'b0, 1'b0, 8'd9},
        // R8: previous fetch missed, decode predicts taken
        '{32'h108, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b1, 1'b1, 1'b1, 32'h800, 32'h800, 1'b1, 1'b0, 8'd8},
        // R4: not-taken resolve of unseen address
        '{32'h800, 1'b1, 32'h200, 1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h804, 1'b0, 1'b0, 8'd4},
        // R4: nothing was allocated for 0x200
        '{32'h200, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h204, 1'b0, 1'b0, 8'd4},
        // R5: taken resolve rewrites 0x100 target to 0x500
        '{32'h300, 1'b1, 32'h100, 1'b1, 32'h500, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h304, 1'b0, 1'b0, 8'd5},
        // R5: new target in use
        '{32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h500, 1'b0, 1'b0, 8'd5},
        // R10: mispredicted not-taken -> ex_pc + 4, flush (also invalidates, R6)
        '{32'h500, 1'b1, 32'h100, 1'b0, 32'h0,   1'b1, 1'b0, 1'b0, 1'b0, 32'h0,   32'h104, 1'b0, 1'b1, 8'd10},
        // R6: 0x100 now misses
        '{32'h100, 1'b0, 32'h0,   1'b0, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0, 32'h0,   32'h104, 1'b0, 1'b0, 8'd6},
        // R10: execute wins over a simultaneous decode override
        '{32'h104, 1'b1, 32'h600, 1'b1, 32'h700, 1'b1, 1'b1, 1'b1, 1'b1, 32'h900, 32'h700, 1'b0, 1'b1, 8'd10}
    };

    logic            clk;
    logic            rst_n;
    logic [PC_W-1:0] fetch_pc;
    logic            dec_valid;
    logic            dec_branch;
    logic            dec_pred_taken;
    logic [PC_W-1:0] dec_target;
    logic            ex_valid;
    logic [PC_W-1:0] ex_pc;
    logic            ex_taken;
    logic [PC_W-1:0] ex_target;
    logic            ex_mispredict;
    logic [PC_W-1:0] next_pc;
    logic            redirect;
    logic            kill_fetch;
    logic            flush;

    int n_checks;
    int n_fails;

    nextpc_unit #(.PC_W(PC_W)) u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .fetch_pc       (fetch_pc),
        .dec_valid      (dec_valid),
        .dec_branch     (dec_branch),
        .dec_pred_taken (dec_pred_taken),
        .dec_target     (dec_target),
        .ex_valid       (ex_valid),
        .ex_pc          (ex_pc),
        .ex_taken       (ex_taken),
        .ex_target      (ex_target),
        .ex_mispredict  (ex_mispredict),
        .next_pc        (next_pc),
        .redirect       (redirect),
        .kill_fetch     (kill_fetch),
        .flush          (flush)
    );

    // 200 MHz clock.
    initial clk = 1'b0;
    always #2.5 clk = ~clk;

    // Watchdog: a hung run is a failure and still prints the summary.
    initial begin
        #100000;
        n_fails++;
        $display("FAIL watchdog expired: actual running expected finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    task automatic idle_inputs(input logic [PC_W-1:0] pc);
        fetch_pc       = pc;
        dec_valid      = 1'b0;
        dec_branch     = 1'b0;
        dec_pred_taken = 1'b0;
        dec_target     = '0;
        ex_valid       = 1'b0;
        ex_pc          = '0;
        ex_taken       = 1'b0;
        ex_target      = '0;
        ex_mispredict  = 1'b0;
    endtask

    task automatic check(input string req, input logic [PC_W-1:0] exp_pc,
                         input logic exp_kill, input logic exp_flush);
        n_checks++;
        if (next_pc !== exp_pc || kill_fetch !== exp_kill || flush !== exp_flush ||
            redirect !== (exp_kill | exp_flush)) begin
            n_fails++;
            $display("FAIL %s: actual npc=%h kill=%b flush=%b redir=%b expected npc=%h kill=%b flush=%b",
                     req, next_pc, kill_fetch, flush, redirect, exp_pc, exp_kill, exp_flush);
        end
    endtask

    // Probe one fetch address with no other activity.
    task automatic probe(input string req, input logic [PC_W-1:0] pc, input logic [PC_W-1:0] exp_pc);
        @(negedge clk);
        idle_inputs(pc);
        #1;
        check(req, exp_pc, 1'b0, 1'b0);
    endtask

    // Present one taken resolution for a cycle.
    task automatic resolve_taken(input logic [PC_W-1:0] pc, input logic [PC_W-1:0] tgt);
        @(negedge clk);
        idle_inputs(32'h40);
        ex_valid  = 1'b1;
        ex_pc     = pc;
        ex_taken  = 1'b1;
        ex_target = tgt;
    endtask

    initial begin
        n_checks = 0;
        n_fails  = 0;
        idle_inputs(32'h100);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        // R1: state during reset
        @(negedge clk);
        #1;
        check("R1 in reset", 32'h104, 1'b0, 1'b0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            fetch_pc       = VEC[i].fpc;
            ex_valid       = VEC[i].exv;
            ex_pc          = VEC[i].expc;
            ex_taken       = VEC[i].ext;
            ex_target      = VEC[i].extgt;
            ex_mispredict  = VEC[i].exm;
            dec_valid      = VEC[i].dv;
            dec_branch     = VEC[i].db;
            dec_pred_taken = VEC[i].dt;
            dec_target     = VEC[i].dtgt;
            #1;
            check($sformatf("R%0d vec%0d", VEC[i].req, i), VEC[i].npc, VEC[i].kill, VEC[i].fl);
        end

        // R10 side effect: the mispredicted taken 0x600 was learned.
        probe("R10 learned", 32'h600, 32'h700);

        // R7: two allocations so far (slots 0 and 1); 16 more wrap the pointer,
        // the last one lands in slot 1 and evicts 0x600.
        for (int k = 0; k < 16; k++) begin
            resolve_taken(32'h1000 + 32'(k * 16), 32'h2000 + 32'(k * 16));
        end
        probe("R7 evicted", 32'h600, 32'h604);
        probe("R7 oldest new kept", 32'h1000, 32'h2000);
        probe("R7 newest kept", 32'h10F0, 32'h20F0);

        // R1: reset mid-run clears every entry.
        @(negedge clk);
        idle_inputs(32'h1000);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        probe("R1 after reset", 32'h1000, 32'h1004);
        probe("R1 after reset 2", 32'h10F0, 32'h10F4);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end
endmodule